// File: doc/BRIEF.md
# Dual-Precision SIMD Multiply-Accumulate Unit

This unit multiplies two 64-bit operand words and adds the products into a bank of accumulator registers. Each operation picks one of three lane arrangements. The first is four independent 16-bit lanes with 40-bit accumulators. The second is a single 32-bit lane with an 80-bit accumulator. The third is two packed complex 16-bit pairs, which can optionally be conjugated. Option bits in the same operation select unsigned or two's-complement operands, integer or fractional scaling, and load-instead-of-add.

Each operation also returns a saturated extraction of the accumulator's value from before the update. This lets a caller read the previous result in the same operation that starts the next one. The unit holds several accumulator banks and an operation selects one of them. All outputs are registered and appear one clock after the start strobe.

Top module: `dual_mac`

## Requirements
- R1: Quad mode (`ctrl[1:0]` = 0, and also 3) treats bits [16i+15:16i] of each operand as lane i, for i = 0..3. It adds the product of the two lane-i values into 40-bit accumulator lane i, wrapping modulo 2^40. Lanes do not interact.
- R2: Wide mode (`ctrl[1:0]` = 1) multiplies `op_a[31:0]` by `op_b[31:0]` into an 80-bit accumulator formed as {lane1, lane0}, wrapping modulo 2^80. Lanes 2 and 3 of the selected bank keep their values.
- R3: Complex mode (`ctrl[1:0]` = 2) treats bits [32k+15:32k] as the real part and bits [32k+31:32k+16] as the imaginary part of pair k, for k = 0..1. It adds ar*br - ai*bi into lane 2k and ar*bi + ai*br into lane 2k+1. Operands in this mode are always two's-complement, and the unsigned option has no effect.
- R4: With the conjugate option (`ctrl[4]`) set in complex mode, the imaginary part of the second operand is negated. Lane 2k then receives ar*br + ai*bi and lane 2k+1 receives ai*br - ar*bi.
- R5: With the unsigned option (`ctrl[2]`) set, quad and wide operands are read as unsigned numbers. When the option is clear, they are read as two's-complement.
- R6: With the integer option (`ctrl[3]`) clear, each product is doubled (fractional scaling). A signed product of the most negative value by itself instead gives 2^(2W-1)-1, where W is the lane width. With the integer option set, the product is used unchanged.
- R7: With the clear option (`ctrl[5]`) set, the product is loaded into each affected lane and the previous content is discarded.
- R8: `res_out` carries, one cycle after the start strobe, an extraction of the selected bank's contents from before that operation's update. In quad and complex modes, lane i goes to `res_out[16i+15:16i]`. In wide mode, the 80-bit value goes to `res_out[31:0]`, and `res_out[63:32]` and `ovf_out[3:1]` are zero.
- R9: The extraction first shifts the accumulator right by the destination width in fractional mode, or leaves it unshifted in integer mode. It then saturates the value to the destination width: signed as two's-complement, unsigned to all-ones. The matching `ovf_out` bit is set exactly when saturation occurred.
- R10: `acc_out`, `res_out`, `ovf_out` and `done` update on the clock edge that samples `start` high, and `done` is high for exactly that following cycle. While `start` is low, no bank changes and the data outputs hold.
- R11: `acc_sel` picks the bank an operation reads and writes. Other banks are untouched.
- R12: After reset, every bank and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one operation in this cycle |
| ctrl | input | 6 | {clear, conjugate, integer, unsigned, mode[1:0]} |
| acc_sel | input | 1 | Accumulator bank select |
| op_a | input | 64 | First operand word |
| op_b | input | 64 | Second operand word |
| acc_out | output | 160 | Updated content of the selected bank, lane i at [40i+39:40i] |
| res_out | output | 64 | Saturated extraction of the bank before the update |
| ovf_out | output | 4 | Per-lane saturation flags for res_out |
| done | output | 1 | One-cycle pulse marking valid outputs |

## Verification
Corrupted accumulator state never reaches the ports directly when the corruption happens. It shows up only when that bank is next selected: in `acc_out` of that operation and in `res_out` of the same operation, one clock after its start strobe. The bench therefore alternates banks and keeps accumulating without clearing across long sweeps, so that a damaged lane from one operation is read back on a later one. A multiplier or sign-handling error shows at once, in the `acc_out` of the operation that caused it.

// File: rtl/simd_mac_pkg.sv
`timescale 1ns/1ps
package simd_mac_pkg;

    localparam int LANE_W_DEF = 16;
    localparam int ACC_W_DEF  = 40;
    localparam int NBANK_DEF  = 2;

    typedef enum logic [1:0] {
        MODE_QUAD = 2'd0,
        MODE_WIDE = 2'd1,
        MODE_CPLX = 2'd2,
        MODE_RSVD = 2'd3
    } mac_mode_e;

    // Operation control word; field order is the port encoding.
    typedef struct packed {
        logic      clr;
        logic      conj;
        logic      intg;
        logic      uns;
        mac_mode_e mode;
    } mac_ctrl_t;

    localparam int CTRL_W = $bits(mac_ctrl_t);

endpackage

// File: rtl/mac_mul.sv
`timescale 1ns/1ps
// One W x W multiplier with sign selection, fractional doubling and
// saturation of the single overflowing signed fractional case.
module mac_mul #(
    parameter int W  = 16,
    parameter int PW = 2 * W + 2
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic          uns,
    input  logic          intg,
    output logic [PW-1:0] p
);
    localparam logic [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [PW-1:0] FRAC_MAX = {{(PW-2*W+1){1'b0}}, {(2*W-1){1'b1}}};

    logic signed [W:0]    a_ext;
    logic signed [W:0]    b_ext;
    logic signed [PW-1:0] raw;
    logic                 both_neg_full;

    always_comb begin
        a_ext         = {(uns ? 1'b0 : a[W-1]), a};
        b_ext         = {(uns ? 1'b0 : b[W-1]), b};
        raw           = PW'(a_ext) * PW'(b_ext);
        both_neg_full = !uns && (a == MOST_NEG) && (b == MOST_NEG);
        if (intg)
            p = raw;
        else if (both_neg_full)
            p = FRAC_MAX;
        else
            p = raw <<< 1;
    end

endmodule

// File: rtl/mac_sat.sv
`timescale 1ns/1ps
// Scales one accumulator down to RW bits and saturates it.
module mac_sat #(
    parameter int AW = 40,
    parameter int RW = 16
) (
    input  logic [AW-1:0] acc,
    input  logic          frac,
    input  logic          uns,
    output logic [RW-1:0] r,
    output logic          ovf
);
    localparam logic [RW-1:0] S_MAX = {1'b0, {(RW-1){1'b1}}};
    localparam logic [RW-1:0] S_MIN = {1'b1, {(RW-1){1'b0}}};

    logic [AW-1:0]    shifted;
    logic [AW-RW-1:0] high_u;
    logic [AW-RW:0]   high_s;

    always_comb begin
        if (!frac)
            shifted = acc;
        else if (uns)
            shifted = acc >> RW;
        else
            shifted = AW'($signed(acc) >>> RW);

        high_u = shifted[AW-1:RW];
        high_s = shifted[AW-1:RW-1];

        if (uns) begin
            ovf = |high_u;
            r   = ovf ? {RW{1'b1}} : shifted[RW-1:0];
        end else begin
            ovf = !((&high_s) || !(|high_s));
            if (ovf)
                r = shifted[AW-1] ? S_MIN : S_MAX;
            else
                r = shifted[RW-1:0];
        end
    end

endmodule

// File: rtl/dual_mac.sv
`timescale 1ns/1ps
module dual_mac
    import simd_mac_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    parameter int ACC_W  = ACC_W_DEF,
    parameter int NBANK  = NBANK_DEF,
    localparam int NLANE  = 4,
    localparam int OP_W   = NLANE * LANE_W,
    localparam int SEL_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [CTRL_W-1:0]      ctrl,
    input  logic [SEL_W-1:0]       acc_sel,
    input  logic [OP_W-1:0]        op_a,
    input  logic [OP_W-1:0]        op_b,
    output logic [NLANE*ACC_W-1:0] acc_out,
    output logic [OP_W-1:0]        res_out,
    output logic [NLANE-1:0]       ovf_out,
    output logic                   done
);
    localparam int WIDE_W = 2 * LANE_W;
    localparam int ACCX_W = 2 * ACC_W;
    localparam int PN_W   = 2 * LANE_W + 2;
    localparam int PX_W   = 2 * WIDE_W + 2;
    localparam int NMUL   = 2 * NLANE;

    typedef logic [NLANE-1:0][ACC_W-1:0] lanes_t;

    typedef struct packed {
        logic [NBANK-1:0][NLANE-1:0][ACC_W-1:0] bank;
        lanes_t                                  acc;
        logic [OP_W-1:0]                         res;
        logic [NLANE-1:0]                        ovf;
        logic                                    done;
    } state_t;

    state_t    st_d, st_q;
    mac_ctrl_t c;
    logic      is_wide, is_cplx, mul_uns, frac;

    assign c       = mac_ctrl_t'(ctrl);
    assign is_wide = (c.mode == MODE_WIDE);
    assign is_cplx = (c.mode == MODE_CPLX);
    assign mul_uns = c.uns && !is_cplx;
    assign frac    = !c.intg;

    logic [NLANE-1:0][LANE_W-1:0] a_l, b_l;
    assign a_l = op_a;
    assign b_l = op_b;

    // ---------------- narrow multipliers, shared by quad and complex ----
    logic [PN_W-1:0] pr [NMUL];

    for (genvar j = 0; j < NMUL; j++) begin : g_mul
        // Complex pair k = j/4; slot r = j%4 picks (ar,br),(ai,bi),(ar,bi),(ai,br).
        localparam int K    = j / 4;
        localparam int R    = j % 4;
        localparam int AIDX = 2 * K + (((R == 1) || (R == 3)) ? 1 : 0);
        localparam int BIDX = 2 * K + (((R == 1) || (R == 2)) ? 1 : 0);
        logic [LANE_W-1:0] ma, mb;
        if (j < NLANE) begin : g_shared
            assign ma = is_cplx ? a_l[AIDX] : a_l[j];
            assign mb = is_cplx ? b_l[BIDX] : b_l[j];
        end else begin : g_cplx_only
            assign ma = a_l[AIDX];
            assign mb = b_l[BIDX];
        end
        mac_mul #(.W(LANE_W), .PW(PN_W)) u_mul (
            .a   (ma),
            .b   (mb),
            .uns (mul_uns),
            .intg(c.intg),
            .p   (pr[j])
        );
    end

    // ---------------- wide multiplier ----------------------------------
    logic [PX_W-1:0] px;

    mac_mul #(.W(WIDE_W), .PW(PX_W)) u_mul_wide (
        .a   (op_a[WIDE_W-1:0]),
        .b   (op_b[WIDE_W-1:0]),
        .uns (c.uns),
        .intg(c.intg),
        .p   (px)
    );

    function automatic logic [ACC_W-1:0] sext_n(input logic [PN_W-1:0] v);
        return {{(ACC_W-PN_W){v[PN_W-1]}}, v};
    endfunction

    // ---------------- per-lane increments -------------------------------
    lanes_t            delta;
    logic [ACCX_W-1:0] delta_x;

    always_comb begin
        for (int k = 0; k < NLANE / 2; k++) begin
            if (c.conj) begin
                delta[2*k]   = sext_n(pr[4*k]) + sext_n(pr[4*k+1]);
                delta[2*k+1] = sext_n(pr[4*k+3]) - sext_n(pr[4*k+2]);
            end else begin
                delta[2*k]   = sext_n(pr[4*k]) - sext_n(pr[4*k+1]);
                delta[2*k+1] = sext_n(pr[4*k+2]) + sext_n(pr[4*k+3]);
            end
        end
        if (!is_cplx) begin
            for (int i = 0; i < NLANE; i++)
                delta[i] = sext_n(pr[i]);
        end
        delta_x = {{(ACCX_W-PX_W){px[PX_W-1]}}, px};
    end

    // ---------------- extraction of the pre-update bank -----------------
    lanes_t                         old_bank;
    logic [NLANE-1:0][LANE_W-1:0]   ext_n;
    logic [NLANE-1:0]               ovf_n;
    logic [WIDE_W-1:0]              ext_x;
    logic                           ovf_x;

    assign old_bank = st_q.bank[acc_sel];

    for (genvar i = 0; i < NLANE; i++) begin : g_sat
        mac_sat #(.AW(ACC_W), .RW(LANE_W)) u_sat (
            .acc (old_bank[i]),
            .frac(frac),
            .uns (mul_uns),
            .r   (ext_n[i]),
            .ovf (ovf_n[i])
        );
    end

    mac_sat #(.AW(ACCX_W), .RW(WIDE_W)) u_sat_wide (
        .acc ({old_bank[1], old_bank[0]}),
        .frac(frac),
        .uns (c.uns),
        .r   (ext_x),
        .ovf (ovf_x)
    );

    // ---------------- next state ----------------------------------------
    lanes_t            new_bank;
    logic [ACCX_W-1:0] old_x, new_x;

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        new_bank  = old_bank;
        old_x     = {old_bank[1], old_bank[0]};
        new_x     = c.clr ? delta_x : old_x + delta_x;

        if (is_wide) begin
            new_bank[0] = new_x[ACC_W-1:0];
            new_bank[1] = new_x[ACCX_W-1:ACC_W];
        end else begin
            for (int i = 0; i < NLANE; i++)
                new_bank[i] = c.clr ? delta[i] : old_bank[i] + delta[i];
        end

        if (start) begin
            st_d.bank[acc_sel] = new_bank;
            st_d.acc           = new_bank;
            if (is_wide) begin
                st_d.res = {{(OP_W-WIDE_W){1'b0}}, ext_x};
                st_d.ovf = {{(NLANE-1){1'b0}}, ovf_x};
            end else begin
                st_d.res = ext_n;
                st_d.ovf = ovf_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc_out = st_q.acc;
    assign res_out = st_q.res;
    assign ovf_out = st_q.ovf;
    assign done    = st_q.done;

endmodule

// File: rtl/dual_mac_chk.sv
`timescale 1ns/1ps
module dual_mac_chk #(
    parameter int LANE_W = 16,
    parameter int ACC_W  = 40,
    localparam int NLANE  = 4,
    localparam int OP_W   = NLANE * LANE_W,
    localparam int WIDE_W = 2 * LANE_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic [1:0]             mode,
    input logic                   clr,
    input logic [OP_W-1:0]        op_a,
    input logic [NLANE*ACC_W-1:0] acc_out,
    input logic [OP_W-1:0]        res_out,
    input logic [NLANE-1:0]       ovf_out,
    input logic                   done
);
    localparam logic [LANE_W-1:0] V_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] V_MIN = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] V_ONE = {LANE_W{1'b1}};

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(acc_out) && $stable(res_out) && $stable(ovf_out))); // R10

    AST_WIDE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 2'd1) |=> (res_out[OP_W-1:WIDE_W] == '0 && ovf_out[NLANE-1:1] == '0)); // R8

    AST_CLEAR_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && clr && mode == 2'd0 && op_a == '0) |=> (acc_out == '0)); // R7

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        AST_OVF_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            (start && mode != 2'd1) |=> (!ovf_out[i] ||
                res_out[LANE_W*i +: LANE_W] == V_MAX ||
                res_out[LANE_W*i +: LANE_W] == V_MIN ||
                res_out[LANE_W*i +: LANE_W] == V_ONE)); // R9
    end

endmodule

bind dual_mac dual_mac_chk #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mode   (ctrl[1:0]),
    .clr    (ctrl[CTRL_W-1]),
    .op_a   (op_a),
    .acc_out(acc_out),
    .res_out(res_out),
    .ovf_out(ovf_out),
    .done   (done)
);

// File: tb/tb_dual_mac.sv
`timescale 1ns/1ps
module tb_dual_mac;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [5:0]   ctrl = '0;
    logic [0:0]   acc_sel = '0;
    logic [63:0]  op_a = '0;
    logic [63:0]  op_b = '0;
    logic [159:0] acc_out;
    logic [63:0]  res_out;
    logic [3:0]   ovf_out;
    logic         done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [3:0][39:0] shb [2];

    always #2.5 clk = ~clk;

    dual_mac dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl), .acc_sel(acc_sel),
        .op_a(op_a), .op_b(op_b), .acc_out(acc_out), .res_out(res_out),
        .ovf_out(ovf_out), .done(done)
    );

    task automatic chk(input string tag, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic signed [127:0] sx(input logic [127:0] v, input int w, input bit uns);
        logic [127:0] m;
        m = v & ((128'd1 << w) - 128'd1);
        if (!uns && m[w-1]) return $signed(m - (128'd1 << w));
        return $signed(m);
    endfunction

    function automatic logic signed [127:0] prod(input logic [127:0] a, input logic [127:0] b,
                                                 input int w, input bit uns, input bit intg);
        logic signed [127:0] pa, pb, p, mn;
        pa = sx(a, w, uns);
        pb = sx(b, w, uns);
        mn = -(128'sd1 <<< (w - 1));
        p  = pa * pb;
        if (!intg) begin
            if (!uns && pa == mn && pb == mn) p = (128'sd1 <<< (2 * w - 1)) - 128'sd1;
            else p = p * 2;
        end
        return p;
    endfunction

    task automatic sat(input logic [127:0] raw, input int aw, input int rw, input bit frac,
                       input bit uns, output logic [63:0] r, output bit o);
        logic signed [127:0] v, s, mx, mn;
        v = sx(raw, aw, uns);
        s = frac ? (v >>> rw) : v;
        o = 0;
        if (uns) begin
            mx = (128'sd1 <<< rw) - 1;
            if (s > mx) begin s = mx; o = 1; end
        end else begin
            mx = (128'sd1 <<< (rw - 1)) - 1;
            mn = -(128'sd1 <<< (rw - 1));
            if (s > mx) begin s = mx; o = 1; end
            if (s < mn) begin s = mn; o = 1; end
        end
        r = 64'(s) & ((64'd1 << rw) - 64'd1);
    endtask

    task automatic run_op(input logic [1:0] md, input bit uns, input bit intg, input bit conj,
                          input bit clr, input bit sel, input logic [63:0] a, input logic [63:0] b);
        logic [3:0][39:0] oldl, newl;
        logic [63:0] eres, r1;
        logic [3:0] eovf;
        logic [127:0] o80, n80;
        logic signed [127:0] d, re, im, rr, ii, ri, ir;
        bit o1, wide, cpx;
        string tg;
        wide = (md == 2'd1);
        cpx  = (md == 2'd2);
        oldl = shb[sel];
        newl = oldl;
        eres = '0;
        eovf = '0;
        if (wide) begin
            tg  = "R2";
            o80 = {48'b0, oldl[1], oldl[0]};
            d   = prod({96'b0, a[31:0]}, {96'b0, b[31:0]}, 32, uns, intg);
            n80 = clr ? d : o80 + d;
            newl[0] = n80[39:0];
            newl[1] = n80[79:40];
            sat(o80, 80, 32, !intg, uns, r1, o1);
            eres = {32'b0, r1[31:0]};
            eovf = {3'b0, o1};
        end else begin
            if (cpx) begin
                tg = "R3";
                for (int k = 0; k < 2; k++) begin
                    rr = prod({112'b0, a[32*k +: 16]}, {112'b0, b[32*k +: 16]}, 16, 0, intg);
                    ii = prod({112'b0, a[32*k+16 +: 16]}, {112'b0, b[32*k+16 +: 16]}, 16, 0, intg);
                    ri = prod({112'b0, a[32*k +: 16]}, {112'b0, b[32*k+16 +: 16]}, 16, 0, intg);
                    ir = prod({112'b0, a[32*k+16 +: 16]}, {112'b0, b[32*k +: 16]}, 16, 0, intg);
                    re = conj ? rr + ii : rr - ii;
                    im = conj ? ir - ri : ri + ir;
                    newl[2*k]   = clr ? re[39:0] : oldl[2*k] + re[39:0];
                    newl[2*k+1] = clr ? im[39:0] : oldl[2*k+1] + im[39:0];
                end
            end else begin
                tg = "R1";
                for (int i = 0; i < 4; i++) begin
                    d = prod({112'b0, a[16*i +: 16]}, {112'b0, b[16*i +: 16]}, 16, uns, intg);
                    newl[i] = clr ? d[39:0] : oldl[i] + d[39:0];
                end
            end
            for (int i = 0; i < 4; i++) begin
                sat({88'b0, oldl[i]}, 40, 16, !intg, uns && !cpx, r1, o1);
                eres[16*i +: 16] = r1[15:0];
                eovf[i] = o1;
            end
        end
        @(negedge clk);
        start = 1'b1; ctrl = {clr, conj, intg, uns, md}; acc_sel = sel; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0;
        chk(tg, "acc_out", acc_out, newl);
        chk("R8", "res_out", {96'b0, res_out}, {96'b0, eres});
        chk("R9", "ovf_out", {156'b0, ovf_out}, {156'b0, eovf});
        chk("R10", "done", {159'b0, done}, 160'd1);
        shb[sel] = newl;
    endtask

    function automatic logic [15:0] v16(input int i);
        case (i % 8)
            0: return 16'h0000; 1: return 16'h0001; 2: return 16'hFFFF; 3: return 16'h7FFF;
            4: return 16'h8000; 5: return 16'h4000; 6: return 16'hC000; default: return 16'h1234;
        endcase
    endfunction

    function automatic logic [31:0] v32(input int i);
        case (i % 8)
            0: return 32'h0000_0000; 1: return 32'h0000_0001; 2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF; 4: return 32'h8000_0000; 5: return 32'h4000_0000;
            6: return 32'h1234_5678; default: return 32'hC000_0001;
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [159:0] held;
        logic [63:0] a, b;
        shb[0] = '0;
        shb[1] = '0;
        repeat (3) @(negedge clk);
        // R12: reset state at the ports
        chk("R12", "acc_out", acc_out, '0);
        chk("R12", "res_out", {96'b0, res_out}, '0);
        chk("R12", "ovf/done", {155'b0, ovf_out, done}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "done idle", {159'b0, done}, '0);

        // R6: signed fractional most-negative squared saturates
        run_op(2'd0, 0, 0, 0, 1, 0, {4{16'h8000}}, {4{16'h8000}});
        chk("R6", "frac min*min", acc_out, {4{40'h00_7FFF_FFFF}});
        // R5: unsigned integer product
        run_op(2'd0, 1, 1, 0, 1, 0, {4{16'hFFFF}}, {4{16'hFFFF}});
        chk("R5", "unsigned FFFF*FFFF", acc_out, {4{40'h00_FFFE_0001}});
        // R4: conjugate complex, integer
        run_op(2'd2, 0, 1, 1, 1, 0, {2{16'h2000, 16'h4000}}, {2{16'h2000, 16'h4000}});
        chk("R4", "conj product", acc_out, {2{40'h0, 40'h00_1400_0000}});
        // R7: clear discards previous content
        run_op(2'd0, 0, 1, 0, 0, 1, {4{16'h0123}}, {4{16'h0011}});
        run_op(2'd0, 0, 1, 0, 1, 1, {4{16'h0005}}, {4{16'h0000}});
        chk("R7", "clear load zero", acc_out, '0);
        // R11: bank isolation
        run_op(2'd0, 0, 1, 0, 1, 1, {4{16'h0007}}, {4{16'h0005}});
        run_op(2'd0, 0, 1, 0, 0, 0, '0, '0);
        chk("R11", "bank0 untouched", acc_out, {2{40'h0, 40'h00_1400_0000}});
        // R10: idle cycles change nothing
        held = acc_out;
        repeat (3) @(negedge clk);
        chk("R10", "idle done low", {159'b0, done}, '0);
        chk("R10", "idle acc hold", acc_out, held);
        run_op(2'd0, 0, 1, 0, 0, 1, '0, '0);
        chk("R11", "bank1 kept", acc_out, {4{40'd35}});

        // sweeps over modes, options and corner operands
        for (int md = 0; md < 3; md++) begin
            for (int opt = 0; opt < 16; opt++) begin
                for (int ia = 0; ia < 8; ia++) begin
                    for (int ib = 0; ib < 8; ib++) begin
                        if (md == 1) begin
                            a = {v32(ia + 3), v32(ia)};
                            b = {v32(ib + 5), v32(ib)};
                        end else begin
                            for (int l = 0; l < 4; l++) begin
                                a[16*l +: 16] = v16(ia + l);
                                b[16*l +: 16] = v16(ib + 3 * l);
                            end
                        end
                        run_op(2'(md), opt[0], opt[1], opt[2], opt[3] && (ia == ib),
                               1'((ia + ib) % 2), a, b);
                    end
                end
            end
        end
        // reserved mode code behaves as quad
        run_op(2'd3, 0, 0, 0, 1, 0, {16'h7FFF, 16'h8000, 16'h4000, 16'h0001},
               {16'h7FFF, 16'h8000, 16'hC000, 16'hFFFF});

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule